// File: doc/BRIEF.md
# User-Mode Hardware Register Read Unit

This unit answers a processor's unprivileged hardware-register read instruction. Each request carries a 5-bit register number, a 3-bit select field and a flag saying whether the core is running with privileged (coprocessor-0) access. The unit decides whether the read is legal. It then returns the chosen source value or a reserved-instruction fault. The source values (CPU number, cache-synchronisation step, cycle counter, counter resolution, performance control 0, a configuration word holding the extended-capability flag, and the user-local register) arrive as input ports. The unit holds none of them.

Privileged software controls unprivileged access through a 32-bit enable mask that the unit stores. Writes to the mask are filtered. Only bits that name a register this core actually offers can be set, and which bits those are depends on feature and ISA-revision inputs. Every read produces a registered response one cycle later. The response holds a valid strobe, a data word and a fault flag.

Top module: `user_hwreg_reader`

## Requirements
- R1: After reset the response valid is 0 and the enable mask is 0, so any unprivileged read of registers 0 to 3 faults.
- R2: A read of an implemented register N that passes its revision and select checks succeeds when privMode is 1 or enable-mask bit N is 1, and faults otherwise.
- R3: A mask write always stores bits 3:0 of the written word.
- R4: A mask write stores bit 4 only when featPerfCnt and isaRev6 are both 1, bit 5 only when isaRev6 is 1, and bit 29 only when featUserLocal is 1. All other bits are stored as 0.
- R5: Register 0 returns srcExcBase[9:0], zero-extended to XLEN bits.
- R6: Register 1 returns srcSyncStep and register 3 returns srcCountRes.
- R7: Register 2 returns srcCycleCount sign-extended from 32 bits to XLEN bits.
- R8: Register 4 returns srcPerfCtl0. It faults when isaRev6 is 0 or rdSel is non-zero, whatever privMode is.
- R9: Register 5 returns srcCfg5[13] in bit 0 with all other bits 0. It faults when isaRev6 is 0.
- R10: Register 29 returns srcUserLocal under the rule of R2.
- R11: A read of register 6 to 28, 30 or 31 always faults.
- R12: rspValid is 1 in exactly the cycle after a cycle with rdReq = 1. A faulting response carries rspData = 0.
- R13: A read in the same cycle as a mask write is judged against the mask held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskWrEn | input | 1 | Write strobe for the enable mask |
| maskWrData | input | 32 | Value offered to the enable mask |
| featPerfCnt | input | 1 | Performance-counter feature present |
| featUserLocal | input | 1 | User-local register feature present |
| isaRev6 | input | 1 | Core implements ISA revision 6 |
| rdReq | input | 1 | Read request strobe |
| rdRegNum | input | 5 | Register number to read |
| rdSel | input | 3 | Select field of the read |
| privMode | input | 1 | Privileged / coprocessor-0 access active |
| srcExcBase | input | 32 | Exception-base register (low 10 bits are the CPU number) |
| srcSyncStep | input | XLEN | Cache-synchronisation step size |
| srcCycleCount | input | 32 | Cycle counter |
| srcCountRes | input | XLEN | Cycle counter resolution |
| srcPerfCtl0 | input | XLEN | Performance control register 0 |
| srcCfg5 | input | 32 | Configuration word 5 (bit 13 = extended-capability flag) |
| srcUserLocal | input | XLEN | User-local register |
| rspValid | output | 1 | Response strobe |
| rspData | output | XLEN | Response data, 0 on a fault |
| rspFault | output | 1 | Reserved-instruction fault |

## Verification
The assertions check on every cycle the properties that need no stored history: the one-cycle response timing, zero data on faults, the unconditional faults for unimplemented numbers, revision-gated registers and a non-zero select on register 4, and that a privileged read of registers 0 to 3 always succeeds. The mask filtering, the value each register returns, and the ordering of a read against a mask write in the same cycle depend on earlier writes and on the source values. Only the bench's scenarios can show these, by comparing against a model mask and a model response.

// File: rtl/user_hwreg_pkg.sv
`timescale 1ns/1ps
package user_hwreg_pkg;

  localparam int REG_NUM_W   = 5;
  localparam int SEL_W       = 3;
  localparam int MASK_W      = 1 << REG_NUM_W;
  localparam int CPUNUM_W    = 10;
  localparam int CYCLE_W     = 32;
  localparam int CFG_W       = 32;
  localparam int XCAP_CFG_BIT = 13;

  // register numbers (also the enable-mask bit positions)
  localparam int REG_CPUNUM   = 0;
  localparam int REG_SYNCSTEP = 1;
  localparam int REG_CYCLES   = 2;
  localparam int REG_CNTRES   = 3;
  localparam int REG_PERFCTL  = 4;
  localparam int REG_XCAP     = 5;
  localparam int REG_ULOCAL   = 29;
  localparam int BASE_BITS    = 4;   // registers 0..3 are always maskable

  typedef enum logic [2:0] {
    SRC_CPUNUM,
    SRC_SYNCSTEP,
    SRC_CYCLES,
    SRC_CNTRES,
    SRC_PERFCTL,
    SRC_XCAP,
    SRC_ULOCAL,
    SRC_NONE
  } srcSel_e;

  typedef struct packed {
    logic    maskWrite;
    logic    respLoad;
    logic    faultSet;
    srcSel_e src;
  } ctrlStrobe_t;

endpackage

// File: rtl/user_hwreg_ctrl.sv
`timescale 1ns/1ps
module user_hwreg_ctrl
  import user_hwreg_pkg::*;
(
  input  logic                 maskWrEn,
  input  logic                 rdReq,
  input  logic [REG_NUM_W-1:0] rdRegNum,
  input  logic [SEL_W-1:0]     rdSel,
  input  logic                 privMode,
  input  logic                 isaRev6,
  input  logic [MASK_W-1:0]    enMask,
  output ctrlStrobe_t          strobe
);

  logic    implemented;
  logic    revisionOk;
  logic    selectOk;
  logic    accessOk;
  srcSel_e srcPick;

  always_comb begin
    implemented = 1'b1;
    revisionOk  = 1'b1;
    selectOk    = 1'b1;
    srcPick     = SRC_NONE;
    case (int'(rdRegNum))
      REG_CPUNUM:   srcPick = SRC_CPUNUM;
      REG_SYNCSTEP: srcPick = SRC_SYNCSTEP;
      REG_CYCLES:   srcPick = SRC_CYCLES;
      REG_CNTRES:   srcPick = SRC_CNTRES;
      REG_PERFCTL: begin
        srcPick    = SRC_PERFCTL;
        revisionOk = isaRev6;
        selectOk   = (rdSel == '0);
      end
      REG_XCAP: begin
        srcPick    = SRC_XCAP;
        revisionOk = isaRev6;
      end
      REG_ULOCAL:   srcPick = SRC_ULOCAL;
      default:      implemented = 1'b0;
    endcase
  end

  assign accessOk = privMode || enMask[rdRegNum];

  always_comb begin
    strobe.maskWrite = maskWrEn;
    strobe.respLoad  = rdReq;
    strobe.faultSet  = rdReq && !(implemented && revisionOk && selectOk && accessOk);
    strobe.src       = srcPick;
  end

endmodule

// File: rtl/user_hwreg_datapath.sv
`timescale 1ns/1ps
module user_hwreg_datapath
  import user_hwreg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [MASK_W-1:0]  maskWrData,
  input  logic               featPerfCnt,
  input  logic               featUserLocal,
  input  logic               isaRev6,
  input  logic [CFG_W-1:0]   srcExcBase,
  input  logic [XLEN-1:0]    srcSyncStep,
  input  logic [CYCLE_W-1:0] srcCycleCount,
  input  logic [XLEN-1:0]    srcCountRes,
  input  logic [XLEN-1:0]    srcPerfCtl0,
  input  logic [CFG_W-1:0]   srcCfg5,
  input  logic [XLEN-1:0]    srcUserLocal,
  output logic [MASK_W-1:0]  enMask,
  output logic               rspValid,
  output logic [XLEN-1:0]    rspData,
  output logic               rspFault
);

  localparam int CPUNUM_PAD = XLEN - CPUNUM_W;
  localparam int CYCLE_PAD  = XLEN - CYCLE_W;

  logic [MASK_W-1:0] acceptMask;
  logic [XLEN-1:0]   readVal;
  logic              unusedSrcBits;

  assign unusedSrcBits = ^{srcExcBase[CFG_W-1:CPUNUM_W],
                           srcCfg5[CFG_W-1:XCAP_CFG_BIT+1],
                           srcCfg5[XCAP_CFG_BIT-1:0]};

  // which mask bits this configuration lets software set
  generate
    for (genvar b = 0; b < MASK_W; b++) begin : g_accept
      if (b < BASE_BITS) begin : g_base
        assign acceptMask[b] = 1'b1;
      end else if (b == REG_PERFCTL) begin : g_perf
        assign acceptMask[b] = featPerfCnt && isaRev6;
      end else if (b == REG_XCAP) begin : g_xcap
        assign acceptMask[b] = isaRev6;
      end else if (b == REG_ULOCAL) begin : g_ulocal
        assign acceptMask[b] = featUserLocal;
      end else begin : g_none
        assign acceptMask[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (strobe.maskWrite) begin
      enMask <= maskWrData & acceptMask;
    end
  end

  always_comb begin
    case (strobe.src)
      SRC_CPUNUM:   readVal = {{CPUNUM_PAD{1'b0}}, srcExcBase[CPUNUM_W-1:0]};
      SRC_SYNCSTEP: readVal = srcSyncStep;
      SRC_CYCLES:   readVal = {{CYCLE_PAD{srcCycleCount[CYCLE_W-1]}}, srcCycleCount};
      SRC_CNTRES:   readVal = srcCountRes;
      SRC_PERFCTL:  readVal = srcPerfCtl0;
      SRC_XCAP:     readVal = {{(XLEN-1){1'b0}}, srcCfg5[XCAP_CFG_BIT]};
      SRC_ULOCAL:   readVal = srcUserLocal;
      default:      readVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.respLoad;
      rspFault <= strobe.faultSet;
      rspData  <= (strobe.respLoad && !strobe.faultSet) ? readVal : '0;
    end
  end

endmodule

// File: rtl/user_hwreg_reader.sv
`timescale 1ns/1ps
module user_hwreg_reader
  import user_hwreg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            maskWrEn,
  input  logic [31:0]     maskWrData,
  input  logic            featPerfCnt,
  input  logic            featUserLocal,
  input  logic            isaRev6,
  input  logic            rdReq,
  input  logic [4:0]      rdRegNum,
  input  logic [2:0]      rdSel,
  input  logic            privMode,
  input  logic [31:0]     srcExcBase,
  input  logic [XLEN-1:0] srcSyncStep,
  input  logic [31:0]     srcCycleCount,
  input  logic [XLEN-1:0] srcCountRes,
  input  logic [XLEN-1:0] srcPerfCtl0,
  input  logic [31:0]     srcCfg5,
  input  logic [XLEN-1:0] srcUserLocal,
  output logic            rspValid,
  output logic [XLEN-1:0] rspData,
  output logic            rspFault
);

  ctrlStrobe_t       strobe;
  logic [MASK_W-1:0] enMask;

  user_hwreg_ctrl u_ctrl (
    .maskWrEn (maskWrEn),
    .rdReq    (rdReq),
    .rdRegNum (rdRegNum),
    .rdSel    (rdSel),
    .privMode (privMode),
    .isaRev6  (isaRev6),
    .enMask   (enMask),
    .strobe   (strobe)
  );

  user_hwreg_datapath #(.XLEN(XLEN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .maskWrData    (maskWrData),
    .featPerfCnt   (featPerfCnt),
    .featUserLocal (featUserLocal),
    .isaRev6       (isaRev6),
    .srcExcBase    (srcExcBase),
    .srcSyncStep   (srcSyncStep),
    .srcCycleCount (srcCycleCount),
    .srcCountRes   (srcCountRes),
    .srcPerfCtl0   (srcPerfCtl0),
    .srcCfg5       (srcCfg5),
    .srcUserLocal  (srcUserLocal),
    .enMask        (enMask),
    .rspValid      (rspValid),
    .rspData       (rspData),
    .rspFault      (rspFault)
  );

endmodule

// File: rtl/user_hwreg_checker.sv
`timescale 1ns/1ps
module user_hwreg_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            isaRev6,
  input logic            rdReq,
  input logic [4:0]      rdRegNum,
  input logic [2:0]      rdSel,
  input logic            privMode,
  input logic            rspValid,
  input logic [XLEN-1:0] rspData,
  input logic            rspFault
);

  logic unimplNum;
  assign unimplNum = (rdRegNum > 5'd5) && (rdRegNum != 5'd29);

  p_req_gives_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rspValid);

  p_idle_no_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rspValid);

  p_fault_zero_data_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspData == '0));

  p_unimpl_faults_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && unimplNum) |=> (rspValid && rspFault));

  p_perf_select_faults_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdRegNum == 5'd4 && rdSel != 3'd0) |=> rspFault);

  p_rev_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !isaRev6 && (rdRegNum == 5'd4 || rdRegNum == 5'd5)) |=> rspFault);

  p_priv_base_ok_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && privMode && rdRegNum < 5'd4) |=> (rspValid && !rspFault));

endmodule

bind user_hwreg_reader user_hwreg_checker #(.XLEN(XLEN)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .isaRev6  (isaRev6),
  .rdReq    (rdReq),
  .rdRegNum (rdRegNum),
  .rdSel    (rdSel),
  .privMode (privMode),
  .rspValid (rspValid),
  .rspData  (rspData),
  .rspFault (rspFault)
);

// File: tb/test_user_hwreg_reader.sv
`timescale 1ns/1ps
module test_user_hwreg_reader;

  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic maskWrEn = 1'b0;
  logic [31:0] maskWrData = '0;
  logic featPerfCnt = 1'b0, featUserLocal = 1'b0, isaRev6 = 1'b0;
  logic rdReq = 1'b0;
  logic [4:0] rdRegNum = '0;
  logic [2:0] rdSel = '0;
  logic privMode = 1'b0;
  logic [31:0] srcExcBase = '0, srcCycleCount = '0, srcCfg5 = '0;
  logic [XLEN-1:0] srcSyncStep = '0, srcCountRes = '0, srcPerfCtl0 = '0, srcUserLocal = '0;
  logic rspValid, rspFault;
  logic [XLEN-1:0] rspData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] modelMask = '0;

  always #2 clk = ~clk;

  user_hwreg_reader #(.XLEN(XLEN)) i_user_hwreg_reader (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .featPerfCnt(featPerfCnt), .featUserLocal(featUserLocal), .isaRev6(isaRev6),
    .rdReq(rdReq), .rdRegNum(rdRegNum), .rdSel(rdSel), .privMode(privMode),
    .srcExcBase(srcExcBase), .srcSyncStep(srcSyncStep), .srcCycleCount(srcCycleCount),
    .srcCountRes(srcCountRes), .srcPerfCtl0(srcPerfCtl0), .srcCfg5(srcCfg5),
    .srcUserLocal(srcUserLocal), .rspValid(rspValid), .rspData(rspData), .rspFault(rspFault)
  );

  function automatic logic [31:0] acceptOf(logic perf, logic ulocal, logic rev6);
    logic [31:0] m = 32'h0000_000F;
    m[4]  = perf && rev6;
    m[5]  = rev6;
    m[29] = ulocal;
    return m;
  endfunction

  // {fault, data}
  function automatic logic [XLEN:0] expectRead(logic [4:0] rn, logic [2:0] s, logic pr,
                                                logic [31:0] mask);
    logic ok = pr || mask[rn];
    logic [XLEN-1:0] v = '0;
    case (rn)
      5'd0:  v = {{(XLEN-10){1'b0}}, srcExcBase[9:0]};
      5'd1:  v = srcSyncStep;
      5'd2:  v = {{(XLEN-32){srcCycleCount[31]}}, srcCycleCount};
      5'd3:  v = srcCountRes;
      5'd4:  begin v = srcPerfCtl0; ok = ok && isaRev6 && (s == 3'd0); end
      5'd5:  begin v = {{(XLEN-1){1'b0}}, srcCfg5[13]}; ok = ok && isaRev6; end
      5'd29: v = srcUserLocal;
      default: ok = 1'b0;
    endcase
    return ok ? {1'b0, v} : {1'b1, {XLEN{1'b0}}};
  endfunction

  function automatic string tagOf(logic [4:0] rn);
    case (rn)
      5'd0: return "R5";
      5'd1, 5'd3: return "R6";
      5'd2: return "R7";
      5'd4: return "R8";
      5'd5: return "R9";
      5'd29: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit cond, string req, string what, logic [XLEN:0] act, logic [XLEN:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: optional mask write and optional read; called at a negedge
  task automatic step(bit wr, logic [31:0] wd, bit rd, logic [4:0] rn, logic [2:0] s,
                      bit pr, string req);
    logic [XLEN:0] exp;
    maskWrEn = wr; maskWrData = wd;
    rdReq = rd; rdRegNum = rn; rdSel = s; privMode = pr;
    exp = expectRead(rn, s, pr, modelMask);   // R13: old mask decides
    if (wr) modelMask = wd & acceptOf(featPerfCnt, featUserLocal, isaRev6);
    @(negedge clk);
    if (rd) begin
      check(rspValid === 1'b1, "R12", "valid", {{XLEN{1'b0}}, rspValid}, {{XLEN{1'b0}}, 1'b1});
      check({rspFault, rspData} === exp, req, "fault/data", {rspFault, rspData}, exp);
    end else begin
      check(rspValid === 1'b0, "R12", "idle valid", {{XLEN{1'b0}}, rspValid}, '0);
    end
    maskWrEn = 1'b0; rdReq = 1'b0;
  endtask

  task automatic randSources();
    srcExcBase    = $urandom;
    srcCycleCount = $urandom;
    srcCfg5       = $urandom;
    srcSyncStep   = {$urandom, $urandom};
    srcCountRes   = {$urandom, $urandom};
    srcPerfCtl0   = {$urandom, $urandom};
    srcUserLocal  = {$urandom, $urandom};
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    randSources();
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0, "R1", "reset valid", {{XLEN{1'b0}}, rspValid}, '0);
    rstN = 1'b1;
    @(negedge clk);
    isaRev6 = 1'b1;

    // R1: mask starts at 0, user reads of 0..3 fault
    for (int r = 0; r < 4; r++) step(0, '0, 1, 5'(r), 3'd0, 0, "R1");
    // R2: privileged reads succeed without mask
    for (int r = 0; r < 6; r++) step(0, '0, 1, 5'(r), 3'd0, 1, "R2");

    // R3/R4: write all ones with features off on revision 6
    featPerfCnt = 0; featUserLocal = 0;
    step(1, 32'hFFFF_FFFF, 0, '0, '0, 0, "R3");
    for (int r = 0; r < 6; r++) step(0, '0, 1, 5'(r), 3'd0, 0, "R4");
    step(0, '0, 1, 5'd29, 3'd0, 0, "R4");
    // features on
    featPerfCnt = 1; featUserLocal = 1;
    step(1, 32'hFFFF_FFFF, 0, '0, '0, 0, "R4");
    step(0, '0, 1, 5'd4, 3'd0, 0, "R4");
    step(0, '0, 1, 5'd29, 3'd0, 0, "R10");
    // not revision 6: bits 4 and 5 dropped, registers 4/5 fault even privileged
    isaRev6 = 0;
    step(1, 32'hFFFF_FFFF, 0, '0, '0, 0, "R4");
    isaRev6 = 1;
    step(0, '0, 1, 5'd4, 3'd0, 0, "R4");
    step(0, '0, 1, 5'd5, 3'd0, 0, "R4");
    isaRev6 = 0;
    step(0, '0, 1, 5'd4, 3'd0, 1, "R8");
    step(0, '0, 1, 5'd5, 3'd0, 1, "R9");
    isaRev6 = 1;
    // R3: selective low bits
    step(1, 32'h0000_0005, 0, '0, '0, 0, "R3");
    for (int r = 0; r < 4; r++) step(0, '0, 1, 5'(r), 3'd0, 0, "R3");

    // R7: negative and positive cycle counts
    srcCycleCount = 32'h8000_0001; step(0, '0, 1, 5'd2, 3'd0, 1, "R7");
    srcCycleCount = 32'h7FFF_FFFF; step(0, '0, 1, 5'd2, 3'd0, 1, "R7");
    // R5: upper exception-base bits dropped
    srcExcBase = 32'hFFFF_F3A5; step(0, '0, 1, 5'd0, 3'd0, 1, "R5");
    // R8: select non-zero faults, zero reads
    step(0, '0, 1, 5'd4, 3'd3, 1, "R8");
    step(0, '0, 1, 5'd4, 3'd0, 1, "R8");
    // R9: flag bit
    srcCfg5 = 32'h0000_2000; step(0, '0, 1, 5'd5, 3'd0, 1, "R9");
    srcCfg5 = 32'hFFFF_DFFF; step(0, '0, 1, 5'd5, 3'd0, 1, "R9");
    // R11: unimplemented, even privileged
    step(0, '0, 1, 5'd6, 3'd0, 1, "R11");
    step(0, '0, 1, 5'd28, 3'd0, 1, "R11");
    step(0, '0, 1, 5'd30, 3'd0, 1, "R11");
    step(0, '0, 1, 5'd31, 3'd0, 1, "R11");

    // R13: write enabling reg 1 with read of reg 1 in same cycle
    step(1, 32'h0000_0000, 0, '0, '0, 0, "R13");
    step(1, 32'h0000_0002, 1, 5'd1, 3'd0, 0, "R13");
    step(0, '0, 1, 5'd1, 3'd0, 0, "R13");
    step(1, 32'h0000_0000, 1, 5'd1, 3'd0, 0, "R13");
    step(0, '0, 1, 5'd1, 3'd0, 0, "R13");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] rn;
      bit wr, rd, pr;
      randSources();
      if ($urandom_range(0, 9) == 0) begin
        featPerfCnt = 1'($urandom); featUserLocal = 1'($urandom); isaRev6 = 1'($urandom);
      end
      case ($urandom_range(0, 3))
        0: rn = 5'($urandom);
        1: rn = 5'd29;
        default: rn = 5'($urandom_range(0, 5));
      endcase
      wr = ($urandom_range(0, 4) == 0);
      rd = ($urandom_range(0, 7) != 0);
      pr = ($urandom_range(0, 2) == 0);
      step(wr, $urandom, rd, rn, 3'($urandom_range(0, 1) == 0 ? 0 : $urandom), pr, tagOf(rn));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule